// File: doc/BRIEF.md
# Light-Load Idle Mode Controller

This block sits beside the gate driver of a secondary-side synchronous rectifier. It decides, one switching cycle at a time, whether the rectifier gate may switch or whether the controller should drop into a low-power idle state. Once per switching cycle it receives a strobe. With that strobe come two values counted in clock ticks: the predicted discharge time of the timing replica and the measured switching period.

Idle is entered when the load gets light, which shows as a short predicted discharge time over several cycles in a row. Idle is left only when the discharge time stays long over a larger number of cycles. The two thresholds and the two cycle counts differ, so the mode has hysteresis. A jump in the switching period forces idle at once, and so do debounced fault levels from the sense inputs. Supply over-voltage and over-temperature only gate the driver off and leave the mode alone. The idle flag would also be used to power down the rest of the controller.

Top module: `lli_idle_ctrl`

## Requirements
- R1: In run mode, a strobe whose `dis_time_i` is below ENTER_TICKS advances the entry count. When ENTER_CYCLES (default 3) such strobes arrive in a row, `idle_o` goes high on the clock edge that samples the last of them.
- R2: In idle mode, a strobe whose `dis_time_i` is strictly above EXIT_TICKS advances the exit count. After EXIT_CYCLES (default 7) such strobes in a row, `idle_o` goes low on the edge that samples the last of them. A value equal to EXIT_TICKS does not count.
- R3: A strobe that fails the condition of the current mode clears that mode's count to zero. This includes values in the band between the two thresholds. Cycles that are not consecutive therefore never change the mode.
- R4: After reset the block is in run mode, both counts are cleared, `idle_o` is 0 and `gate_en_o` is 1.
- R5: A strobe whose `period_i` times 5 exceeds the previous strobe's period times 6 sets `idle_o` on the edge that samples it. A period of exactly 120% of the previous one does not. The first strobe after reset has no reference and never faults.
- R6: When `sense_open_i` has been high for OPEN_DB consecutive clocks, idle is forced on the next edge. A shorter pulse has no effect.
- R7: When `fb_low_i` has been high for SHORT_DB consecutive clocks, idle is forced. While the debounced level persists, exit strobes are not counted.
- R8: When `ovp_i` has been high for OVP_DB consecutive clocks, `gate_en_o` goes low and the mode does not change. One clock after `ovp_i` falls, `gate_en_o` is released.
- R9: While `otp_i` is high, `gate_en_o` is low in the same cycle, without any change of mode.
- R10: While `idle_o` is high, `gate_en_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cycle_done_i | input | 1 | One-clock strobe at the end of each switching cycle |
| dis_time_i | input | CNT_W | Predicted discharge time in ticks, valid with the strobe |
| period_i | input | CNT_W | Switching period in ticks, valid with the strobe |
| sense_open_i | input | 1 | Raw winding-sense open comparator level |
| fb_low_i | input | 1 | Raw output-sense low comparator level |
| ovp_i | input | 1 | Raw supply over-voltage comparator level |
| otp_i | input | 1 | Over-temperature flag with external hysteresis |
| idle_o | output | 1 | Idle mode flag |
| gate_en_o | output | 1 | Permission for the rectifier gate to switch |

## Verification
The assertions assume the following about the inputs:
- `cycle_done_i` is a pulse one clock long.
- `dis_time_i` and `period_i` are meaningful only in the cycle of that pulse.
- All fault levels are already synchronous to `clk_i`.

The bench drives every input on the falling clock edge and holds each strobe for exactly one clock. Between strobes it keeps the period constant, except where a period jump is the stimulus. This way a period fault appears only in the scenario that asks for it.

// File: rtl/lli_pkg.sv
package lli_pkg;
  typedef enum logic {
    MODE_RUN  = 1'b0,
    MODE_IDLE = 1'b1
  } mode_e;

  localparam int unsigned JUMP_NUM = 6; // period limit = prev * 6 / 5
  localparam int unsigned JUMP_DEN = 5;
endpackage

// File: rtl/lli_debounce.sv
module lli_debounce #(
  parameter int unsigned DB_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic flag_o
);
  localparam int unsigned CW = $clog2(DB_CYCLES + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(DB_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!raw_i)           cnt_q <= '0;
    else if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign flag_o = (cnt_q == CNT_TOP);

  AST_FLAG_NEEDS_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o |-> $past(raw_i)); // R6 R7 R8
  AST_RAW_LOW_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !raw_i |=> !flag_o); // R8
endmodule

// File: rtl/lli_period_chk.sv
module lli_period_chk #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             fault_o
);
  import lli_pkg::*;
  localparam int unsigned MW = CNT_W + 3;

  logic [CNT_W-1:0] prev_q;
  logic             have_prev_q;
  logic [MW-1:0]    cur_scaled;
  logic [MW-1:0]    ref_scaled;

  assign cur_scaled = MW'(period_i) * MW'(JUMP_DEN);
  assign ref_scaled = MW'(prev_q) * MW'(JUMP_NUM);
  assign fault_o    = strobe_i && have_prev_q && (cur_scaled > ref_scaled);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q      <= '0;
      have_prev_q <= 1'b0;
    end else if (strobe_i) begin
      prev_q      <= period_i;
      have_prev_q <= 1'b1;
    end
  end

  AST_FAULT_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> strobe_i); // R5
  AST_NO_FAULT_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !have_prev_q) |-> !fault_o); // R5
endmodule

// File: rtl/lli_mode_fsm.sv
module lli_mode_fsm #(
  parameter int unsigned CNT_W        = 16,
  parameter int unsigned ENTER_TICKS  = 960,
  parameter int unsigned EXIT_TICKS   = 1070,
  parameter int unsigned ENTER_CYCLES = 3,
  parameter int unsigned EXIT_CYCLES  = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic [CNT_W-1:0] dis_time_i,
  input  logic             force_i,
  output lli_pkg::mode_e   mode_o
);
  import lli_pkg::*;
  localparam int unsigned ECW = $clog2(ENTER_CYCLES + 1);
  localparam int unsigned XCW = $clog2(EXIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] ENT_T  = CNT_W'(ENTER_TICKS);
  localparam logic [CNT_W-1:0] EXT_T  = CNT_W'(EXIT_TICKS);
  localparam logic [ECW-1:0]   ENT_LAST = ECW'(ENTER_CYCLES - 1);
  localparam logic [XCW-1:0]   EXT_LAST = XCW'(EXIT_CYCLES - 1);

  mode_e          mode_q, mode_d;
  logic [ECW-1:0] ent_cnt_q, ent_cnt_d;
  logic [XCW-1:0] ext_cnt_q, ext_cnt_d;
  logic           short_cyc, long_cyc;

  assign short_cyc = dis_time_i < ENT_T;
  assign long_cyc  = dis_time_i > EXT_T;

  always_comb begin
    mode_d    = mode_q;
    ent_cnt_d = ent_cnt_q;
    ext_cnt_d = ext_cnt_q;
    if (force_i) begin
      mode_d    = MODE_IDLE;
      ent_cnt_d = '0;
      ext_cnt_d = '0;
    end else if (strobe_i) begin
      unique case (mode_q)
        MODE_RUN: begin
          if (!short_cyc) ent_cnt_d = '0;
          else if (ent_cnt_q == ENT_LAST) begin
            mode_d    = MODE_IDLE;
            ent_cnt_d = '0;
          end else ent_cnt_d = ent_cnt_q + 1'b1;
        end
        MODE_IDLE: begin
          if (!long_cyc) ext_cnt_d = '0;
          else if (ext_cnt_q == EXT_LAST) begin
            mode_d    = MODE_RUN;
            ext_cnt_d = '0;
          end else ext_cnt_d = ext_cnt_q + 1'b1;
        end
        default: mode_d = MODE_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_RUN;
      ent_cnt_q <= '0;
      ext_cnt_q <= '0;
    end else begin
      mode_q    <= mode_d;
      ent_cnt_q <= ent_cnt_d;
      ext_cnt_q <= ext_cnt_d;
    end
  end

  assign mode_o = mode_q;

  AST_ENT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_cnt_q < ECW'(ENTER_CYCLES)); // R1
  AST_EXT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_cnt_q < XCW'(EXIT_CYCLES)); // R2
  AST_ENTRY_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_q == MODE_IDLE) |-> $past(force_i || (strobe_i && short_cyc))); // R1
  AST_EXIT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mode_q == MODE_IDLE) |-> $past(strobe_i && long_cyc && !force_i)); // R2
  AST_FORCE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> (mode_q == MODE_IDLE)); // R5
  AST_NO_STROBE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_i && !force_i) |=> $stable(mode_q)); // R3
endmodule

// File: rtl/lli_idle_ctrl.sv
module lli_idle_ctrl #(
  parameter int unsigned CNT_W        = 16,
  parameter int unsigned ENTER_TICKS  = 960,
  parameter int unsigned EXIT_TICKS   = 1070,
  parameter int unsigned ENTER_CYCLES = 3,
  parameter int unsigned EXIT_CYCLES  = 7,
  parameter int unsigned OPEN_DB      = 200,
  parameter int unsigned SHORT_DB     = 300,
  parameter int unsigned OVP_DB       = 14000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cycle_done_i,
  input  logic [CNT_W-1:0] dis_time_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             sense_open_i,
  input  logic             fb_low_i,
  input  logic             ovp_i,
  input  logic             otp_i,
  output logic             idle_o,
  output logic             gate_en_o
);
  import lli_pkg::*;

  logic  open_flag, short_flag, ovp_flag, period_fault, force_idle;
  mode_e mode;

  lli_debounce #(.DB_CYCLES(OPEN_DB)) u_open_db (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(sense_open_i), .flag_o(open_flag));
  lli_debounce #(.DB_CYCLES(SHORT_DB)) u_short_db (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(fb_low_i), .flag_o(short_flag));
  lli_debounce #(.DB_CYCLES(OVP_DB)) u_ovp_db (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(ovp_i), .flag_o(ovp_flag));

  lli_period_chk #(.CNT_W(CNT_W)) u_period (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(cycle_done_i),
    .period_i(period_i), .fault_o(period_fault));

  assign force_idle = period_fault | open_flag | short_flag;

  lli_mode_fsm #(
    .CNT_W(CNT_W), .ENTER_TICKS(ENTER_TICKS), .EXIT_TICKS(EXIT_TICKS),
    .ENTER_CYCLES(ENTER_CYCLES), .EXIT_CYCLES(EXIT_CYCLES)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(cycle_done_i),
    .dis_time_i(dis_time_i), .force_i(force_idle), .mode_o(mode));

  assign idle_o    = (mode == MODE_IDLE);
  assign gate_en_o = !idle_o && !ovp_flag && !otp_i;

  AST_OPEN_FORCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_flag |=> idle_o); // R6
  AST_SHORT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_flag |=> idle_o); // R7
  AST_OVP_KEEPS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovp_flag && !force_idle && !cycle_done_i) |=> $stable(idle_o)); // R8
endmodule

// File: tb/lli_idle_ctrl_tb_top.sv
module lli_idle_ctrl_tb_top;
  localparam int unsigned CW   = 16;
  localparam int unsigned ENT  = 40;
  localparam int unsigned EXT  = 50;
  localparam int unsigned NENT = 3;
  localparam int unsigned NEXT = 7;
  localparam int unsigned ODB  = 8;
  localparam int unsigned SDB  = 12;
  localparam int unsigned VDB  = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cycle_done = 1'b0;
  logic [CW-1:0] dis_time = '0;
  logic [CW-1:0] period = '0;
  logic sense_open = 1'b0, fb_low = 1'b0, ovp = 1'b0, otp = 1'b0;
  logic idle, gate_en;
  int checks = 0, errors = 0;
  int cur_period = 100;

  always #2.5 clk = ~clk;

  lli_idle_ctrl #(
    .CNT_W(CW), .ENTER_TICKS(ENT), .EXIT_TICKS(EXT), .ENTER_CYCLES(NENT),
    .EXIT_CYCLES(NEXT), .OPEN_DB(ODB), .SHORT_DB(SDB), .OVP_DB(VDB)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cycle_done_i(cycle_done),
    .dis_time_i(dis_time), .period_i(period), .sense_open_i(sense_open),
    .fb_low_i(fb_low), .ovp_i(ovp), .otp_i(otp),
    .idle_o(idle), .gate_en_o(gate_en));

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic strobe(input int dis);
    @(negedge clk);
    cycle_done = 1'b1;
    dis_time   = CW'(dis);
    period     = CW'(cur_period);
    @(negedge clk);
    cycle_done = 1'b0;
  endtask

  task automatic leave_idle();
    for (int i = 0; i < NEXT; i++) strobe(EXT + 10);
  endtask

  task automatic t_reset();
    check("R4 idle", idle, 1'b0);
    check("R4 gate", gate_en, 1'b1);
  endtask

  task automatic t_enter_exit();
    strobe(ENT - 10); strobe(ENT - 10);
    check("R1 two short", idle, 1'b0);
    strobe(ENT - 10);
    check("R1 third short", idle, 1'b1);
    check("R10 gate off idle", gate_en, 1'b0);
    for (int i = 0; i < NEXT - 1; i++) strobe(EXT + 10);
    check("R2 six long", idle, 1'b1);
    strobe(EXT);
    check("R2 equal not counted", idle, 1'b1);
    for (int i = 0; i < NEXT - 1; i++) strobe(EXT + 10);
    check("R3 count restarted", idle, 1'b1);
    strobe(EXT + 10);
    check("R2 seventh long", idle, 1'b0);
    check("R2 gate back", gate_en, 1'b1);
  endtask

  task automatic t_band();
    strobe(ENT - 1); strobe(ENT - 1); strobe(ENT + 5); strobe(ENT - 1); strobe(ENT - 1);
    check("R3 broken run", idle, 1'b0);
    strobe(ENT - 1);
    check("R3 fresh run enters", idle, 1'b1);
    leave_idle();
    check("R2 recovered", idle, 1'b0);
  endtask

  task automatic t_period();
    cur_period = 120; strobe(100);
    check("R5 exactly 120pct", idle, 1'b0);
    cur_period = 145; strobe(100);
    check("R5 jump forces idle", idle, 1'b1);
    leave_idle();
    check("R5 recovered", idle, 1'b0);
  endtask

  task automatic t_open();
    @(negedge clk) sense_open = 1'b1;
    repeat (ODB - 1) @(negedge clk);
    sense_open = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 short pulse ignored", idle, 1'b0);
    sense_open = 1'b1;
    repeat (ODB) @(negedge clk);
    check("R6 before debounce", idle, 1'b0);
    @(negedge clk);
    check("R6 open forces idle", idle, 1'b1);
    sense_open = 1'b0;
    leave_idle();
    check("R6 recovered", idle, 1'b0);
  endtask

  task automatic t_short();
    @(negedge clk) fb_low = 1'b1;
    repeat (SDB + 1) @(negedge clk);
    check("R7 short forces idle", idle, 1'b1);
    leave_idle();
    check("R7 exit blocked", idle, 1'b1);
    fb_low = 1'b0;
    leave_idle();
    check("R7 recovered", idle, 1'b0);
  endtask

  task automatic t_ovp();
    @(negedge clk) ovp = 1'b1;
    repeat (VDB - 1) @(negedge clk);
    check("R8 before debounce", gate_en, 1'b1);
    @(negedge clk);
    check("R8 gate off", gate_en, 1'b0);
    check("R8 mode kept", idle, 1'b0);
    ovp = 1'b0;
    @(negedge clk);
    check("R8 released", gate_en, 1'b1);
  endtask

  task automatic t_otp();
    @(negedge clk) otp = 1'b1;
    #1;
    check("R9 gate off", gate_en, 1'b0);
    check("R9 mode kept", idle, 1'b0);
    @(negedge clk) otp = 1'b0;
    #1;
    check("R9 released", gate_en, 1'b1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        strobe(100); // first reference period
        t_enter_exit();
        t_band();
        t_period();
        t_open();
        t_short();
        t_ovp();
        t_otp();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule